// File: doc/BRIEF.md
# Data-Strobe Serial Link Transceiver

This block connects a link-layer controller to a pair of serial lines that carry a data signal and a strobe signal. On the transmit side it takes a two-bit word from the link once per link clock period and sends the two bits out one after the other, more significant bit first. The data line always shows the bit being sent. The strobe line toggles only when a bit repeats the one before it, so exactly one of the two lines changes in every bit cell.

On the receive side the block XORs the incoming data and strobe lines to recover a bit clock. Every edge of that clock carries one new bit. Bits taken on a rising edge become the upper half of a word and bits taken on the next falling edge the lower half. Complete words go through a small gray-coded dual-clock FIFO into the local clock domain and are handed to the link with a one-cycle valid pulse.

The reference oscillator input is the only free-running clock. The block divides it down to make the link clock: by two in full-rate mode and by four in half-rate mode. The serial bit cell lasts half a link clock period in either mode.

Top module: `ds_link_xcvr`

## Requirements
- R1: While `rst` is high (synchronous to `clk`), both outgoing lines, `link_clk_o` and `rx_valid_o` are low, and no word remains pending in the transmit or receive path.
- R2: `link_clk_o` has a period of 2 `clk` cycles when `full_rate_i` is 1 and 4 `clk` cycles when `full_rate_i` is 0.
- R3: `tx_word_i` is sampled on the `clk` edge where `link_clk_o` falls, and only if `tx_en_i` is 1 at that edge. While no word is being sent, neither line changes.
- R4: A sampled word goes out as two bit cells, bit 1 first and bit 0 second. Each bit cell lasts 1 `clk` cycle in full-rate mode and 2 in half-rate mode, and the first cell starts at the sampling edge.
- R5: After each bit cell starts, `tx_data_o` equals the value of that bit.
- R6: In every bit cell exactly one line changes. The strobe toggles when the bit equals the previous value of the data line, and otherwise the data line toggles.
- R7: The receiver takes one bit per edge of `rx_data_i XOR rx_strb_i`. Starting from idle-low lines, the bit on each rising edge becomes bit 1 and the bit on the following falling edge becomes bit 0 of an output word.
- R8: Each received word appears on `rx_word_o` with `rx_valid_o` high for exactly one `clk` cycle. That cycle always directly follows a falling edge of `link_clk_o`, and words come out in arrival order.
- R9: When the line rate matches the local link rate, the receive FIFO never overflows and no word is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| full_rate_i | input | 1 | 1 selects full rate, 0 selects half rate |
| link_clk_o | output | 1 | Divided clock supplied to the link |
| tx_en_i | input | 1 | Word on tx_word_i is valid for sending |
| tx_word_i | input | 2 | Word to transmit, bit 1 sent first |
| tx_data_o | output | 1 | Encoded outgoing data line |
| tx_strb_o | output | 1 | Encoded outgoing strobe line |
| rx_data_i | input | 1 | Incoming data line |
| rx_strb_i | input | 1 | Incoming strobe line |
| rx_word_o | output | 2 | Received word, bit 1 received first |
| rx_valid_o | output | 1 | One-cycle pulse marking a new rx_word_o |

## Verification
The assertions check on every cycle that reset idles the lines, that at most one line changes per bit cell and that the lines stay still between cells, that full-rate link clock toggles every cycle, that the valid pulse follows a word boundary, and that the write pointer never runs a full FIFO ahead of the read pointer. The order of bits on the lines, the values they carry, the regrouping of rising-edge and falling-edge bits into words, and the lossless delivery through the clock crossing can only be shown by the loopback scenarios. In those scenarios the bench predicts every line transition and every delivered word from the words it sends, across several data patterns, both rates, idle gaps and a reset in the middle of a run.

// File: rtl/ds_link_pkg.sv
package ds_link_pkg;

  localparam int DS_WORD_W = 2;
  localparam int DS_DIV_W  = 2;

  typedef logic [DS_WORD_W-1:0] ds_word_t;

  typedef enum logic {
    RATE_HALF = 1'b0,
    RATE_FULL = 1'b1
  } ds_rate_e;

  // Next strobe value: toggle only when the bit repeats the current data line.
  function automatic logic strobe_next(logic bit_v, logic data_now, logic strb_now);
    return (bit_v == data_now) ? ~strb_now : strb_now;
  endfunction

  // Bit cells per link clock period in either rate.
  function automatic int bits_per_word();
    return DS_WORD_W;
  endfunction

endpackage

// File: rtl/ds_clkgen.sv
module ds_clkgen
  import ds_link_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic full_rate,
  output logic bit_en,
  output logic sys_en,
  output logic link_clk
);

  localparam logic [DS_DIV_W-1:0] CNT_ONE = 1;

  logic [DS_DIV_W-1:0] cnt_q;
  ds_rate_e            rate;

  assign rate = ds_rate_e'(full_rate);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + CNT_ONE;
  end

  always_comb begin
    if (rate == RATE_FULL) begin
      bit_en   = 1'b1;
      sys_en   = cnt_q[0];
      link_clk = cnt_q[0];
    end else begin
      bit_en   = cnt_q[0];
      sys_en   = &cnt_q;
      link_clk = cnt_q[1];
    end
  end

endmodule

// File: rtl/ds_tx_serdes.sv
module ds_tx_serdes
  import ds_link_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     bit_en,
  input  logic     sys_en,
  input  logic     tx_en,
  input  ds_word_t tx_word,
  output logic     bit_fire,
  output logic     bit_val,
  output logic     tx_data,
  output logic     tx_strb
);

  logic lsb_q;
  logic pend_q;

  // A cell is sent at a word boundary when a new word is taken, or in the
  // following cell when the low half of that word is still pending.
  always_comb begin
    bit_fire = bit_en && (sys_en ? tx_en : pend_q);
    bit_val  = sys_en ? tx_word[DS_WORD_W-1] : lsb_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lsb_q   <= 1'b0;
      pend_q  <= 1'b0;
      tx_data <= 1'b0;
      tx_strb <= 1'b0;
    end else begin
      if (bit_en) begin
        if (sys_en) begin
          lsb_q  <= tx_word[0];
          pend_q <= tx_en;
        end else begin
          pend_q <= 1'b0;
        end
      end
      if (bit_fire) begin
        tx_data <= bit_val;
        tx_strb <= strobe_next(bit_val, tx_data, tx_strb);
      end
    end
  end

endmodule

// File: rtl/ds_bit_sync.sv
module ds_bit_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/ds_rx_capture.sv
module ds_rx_capture
  import ds_link_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 3
) (
  input  logic                 clear,
  input  logic                 rx_data,
  input  logic                 rx_strb,
  output logic                 bclk,
  output ds_word_t [DEPTH-1:0] mem_q,
  output logic [AW:0]          wr_bin,
  output logic [AW:0]          wr_gray
);

  localparam logic [AW:0] PTR_ONE = 1;

  function automatic logic [AW:0] to_gray(logic [AW:0] b);
    return b ^ (b >> 1);
  endfunction

  logic hi_bit_q;

  // One edge of the recovered clock per bit cell.
  assign bclk = rx_data ^ rx_strb;

  always_ff @(posedge bclk) hi_bit_q <= rx_data;

  always_ff @(negedge bclk or posedge clear) begin
    if (clear) begin
      wr_bin  <= '0;
      wr_gray <= '0;
    end else begin
      wr_bin  <= wr_bin + PTR_ONE;
      wr_gray <= to_gray(wr_bin + PTR_ONE);
    end
  end

  always_ff @(negedge bclk) mem_q[wr_bin[AW-1:0]] <= {hi_bit_q, rx_data};

endmodule

// File: rtl/ds_rx_resync.sv
module ds_rx_resync
  import ds_link_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sys_en,
  input  logic [AW:0]          wr_gray_s,
  input  ds_word_t [DEPTH-1:0] mem_q,
  output ds_word_t             rx_word,
  output logic                 rx_valid,
  output logic [AW:0]          rd_bin,
  output logic                 empty
);

  localparam logic [AW:0] PTR_ONE = 1;

  function automatic logic [AW:0] to_gray(logic [AW:0] b);
    return b ^ (b >> 1);
  endfunction

  logic [AW:0] rd_gray;

  assign rd_gray = to_gray(rd_bin);
  assign empty   = (rd_gray == wr_gray_s);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_bin   <= '0;
      rx_word  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (sys_en && !empty) begin
        rx_word  <= mem_q[rd_bin[AW-1:0]];
        rx_valid <= 1'b1;
        rd_bin   <= rd_bin + PTR_ONE;
      end
    end
  end

endmodule

// File: rtl/ds_link_xcvr.sv
module ds_link_xcvr
  import ds_link_pkg::*;
#(
  parameter int FIFO_DEPTH  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       full_rate_i,
  output logic       link_clk_o,
  input  logic       tx_en_i,
  input  logic [1:0] tx_word_i,
  output logic       tx_data_o,
  output logic       tx_strb_o,
  input  logic       rx_data_i,
  input  logic       rx_strb_i,
  output logic [1:0] rx_word_o,
  output logic       rx_valid_o
);

  localparam int AW = $clog2(FIFO_DEPTH);

  // Internal events brought out for the checker.
  logic                      bit_en;
  logic                      sys_en;
  logic                      tx_bit_fire;
  logic                      tx_bit_val;
  logic                      bclk;
  logic                      cap_clear;
  logic [AW:0]               wr_bin;
  logic [AW:0]               wr_gray;
  logic [AW:0]               wr_gray_s;
  logic [AW:0]               rd_bin;
  logic                      rx_empty;
  ds_word_t [FIFO_DEPTH-1:0] rx_mem;

  // Registered copy of reset, used only as the capture-side clear.
  always_ff @(posedge clk) cap_clear <= rst;

  ds_clkgen u_clkgen (
    .clk      (clk),
    .rst      (rst),
    .full_rate(full_rate_i),
    .bit_en   (bit_en),
    .sys_en   (sys_en),
    .link_clk (link_clk_o)
  );

  ds_tx_serdes u_tx (
    .clk     (clk),
    .rst     (rst),
    .bit_en  (bit_en),
    .sys_en  (sys_en),
    .tx_en   (tx_en_i),
    .tx_word (tx_word_i),
    .bit_fire(tx_bit_fire),
    .bit_val (tx_bit_val),
    .tx_data (tx_data_o),
    .tx_strb (tx_strb_o)
  );

  ds_rx_capture #(.DEPTH(FIFO_DEPTH), .AW(AW)) u_cap (
    .clear  (cap_clear),
    .rx_data(rx_data_i),
    .rx_strb(rx_strb_i),
    .bclk   (bclk),
    .mem_q  (rx_mem),
    .wr_bin (wr_bin),
    .wr_gray(wr_gray)
  );

  ds_bit_sync #(.W(AW + 1), .STAGES(SYNC_STAGES)) u_wsync (
    .clk(clk),
    .rst(rst),
    .d  (wr_gray),
    .q  (wr_gray_s)
  );

  ds_rx_resync #(.DEPTH(FIFO_DEPTH), .AW(AW)) u_resync (
    .clk      (clk),
    .rst      (rst),
    .sys_en   (sys_en),
    .wr_gray_s(wr_gray_s),
    .mem_q    (rx_mem),
    .rx_word  (rx_word_o),
    .rx_valid (rx_valid_o),
    .rd_bin   (rd_bin),
    .empty    (rx_empty)
  );

endmodule

// File: rtl/ds_link_chk.sv
module ds_link_chk #(
  parameter int FIFO_DEPTH = 8
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          full_rate_i,
  input logic                          link_clk_o,
  input logic                          tx_data_o,
  input logic                          tx_strb_o,
  input logic                          rx_valid_o,
  input logic                          bit_en,
  input logic                          sys_en,
  input logic                          tx_bit_fire,
  input logic                          tx_bit_val,
  input logic                          bclk,
  input logic [$clog2(FIFO_DEPTH):0]   wr_bin,
  input logic [$clog2(FIFO_DEPTH):0]   rd_bin
);

  localparam int AW = $clog2(FIFO_DEPTH);
  localparam logic [AW:0] DEPTH_V = FIFO_DEPTH;

  // R1
  rst_idle_chk: assert property (@(posedge clk)
    rst |=> (!tx_data_o && !tx_strb_o && !rx_valid_o));

  // R2
  full_link_clk_chk: assert property (@(posedge clk) disable iff (rst)
    full_rate_i |=> (link_clk_o != $past(link_clk_o)));

  // R3
  word_edge_chk: assert property (@(posedge clk) disable iff (rst)
    sys_en |-> (bit_en && link_clk_o));

  // R5
  data_value_chk: assert property (@(posedge clk) disable iff (rst)
    tx_bit_fire |=> (tx_data_o == $past(tx_bit_val)));

  // R6
  one_line_chk: assert property (@(posedge clk) disable iff (rst)
    tx_bit_fire |=> ($countones({tx_data_o ^ $past(tx_data_o),
                                 tx_strb_o ^ $past(tx_strb_o)}) == 1));

  // R6
  line_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_bit_fire |=> ($stable(tx_data_o) && $stable(tx_strb_o)));

  // R8
  valid_slot_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid_o |-> $past(sys_en));

  // R9
  no_overflow_chk: assert property (@(negedge bclk) disable iff (rst)
    ((wr_bin - rd_bin) < DEPTH_V));

endmodule

bind ds_link_xcvr ds_link_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .full_rate_i(full_rate_i),
  .link_clk_o (link_clk_o),
  .tx_data_o  (tx_data_o),
  .tx_strb_o  (tx_strb_o),
  .rx_valid_o (rx_valid_o),
  .bit_en     (bit_en),
  .sys_en     (sys_en),
  .tx_bit_fire(tx_bit_fire),
  .tx_bit_val (tx_bit_val),
  .bclk       (bclk),
  .wr_bin     (wr_bin),
  .rd_bin     (rd_bin)
);

// File: tb/ds_link_xcvr_test.sv
module ds_link_xcvr_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       full_rate = 1'b1;
  logic       tx_en = 1'b0;
  logic [1:0] tx_word = 2'b00;
  wire        link_clk;
  wire        tx_data;
  wire        tx_strb;
  wire  [1:0] rx_word;
  wire        rx_valid;

  always #4 clk = ~clk;

  ds_link_xcvr uut (
    .clk        (clk),
    .rst        (rst),
    .full_rate_i(full_rate),
    .link_clk_o (link_clk),
    .tx_en_i    (tx_en),
    .tx_word_i  (tx_word),
    .tx_data_o  (tx_data),
    .tx_strb_o  (tx_strb),
    .rx_data_i  (tx_data),
    .rx_strb_i  (tx_strb),
    .rx_word_o  (rx_word),
    .rx_valid_o (rx_valid)
  );

  int         n_chk = 0;
  int         n_fail = 0;
  int         line_changes = 0;
  bit         finished = 0;
  logic       prev_d = 1'b0;
  logic       prev_s = 1'b0;
  logic       exp_bit;
  logic [1:0] exp_word;
  logic [7:0] lfsr = 8'hA5;
  logic [1:0] exp_words[$];
  logic       exp_bits[$];

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // Monitor: line transitions against expected bits, words against expected words.
  always @(negedge clk) begin
    if (!rst && ((tx_data !== prev_d) || (tx_strb !== prev_s))) begin
      line_changes++;
      check(!((tx_data !== prev_d) && (tx_strb !== prev_s)), "R6",
            "both lines changed in one cell", 2, 1);
      if (exp_bits.size() == 0) begin
        check(0, "R3", "line change with no word sent", 1, 0);
      end else begin
        exp_bit = exp_bits.pop_front();
        check(tx_data === exp_bit, "R5", "data line vs bit (R4 order)", int'(tx_data), int'(exp_bit));
      end
    end
    prev_d = tx_data;
    prev_s = tx_strb;
    if (!rst && rx_valid) begin
      check(link_clk === 1'b0, "R8", "valid outside word slot", int'(link_clk), 0);
      if (exp_words.size() == 0) begin
        check(0, "R8", "unexpected received word", int'(rx_word), -1);
      end else begin
        exp_word = exp_words.pop_front();
        check(rx_word === exp_word, "R7", "received word", int'(rx_word), int'(exp_word));
      end
    end
  end

  task automatic do_reset(bit fr);
    @(posedge clk); #1;
    rst = 1'b1;
    full_rate = fr;
    tx_en = 1'b0;
    repeat (6) @(posedge clk);
    #1;
    check(tx_data === 1'b0 && tx_strb === 1'b0, "R1", "lines in reset",
          int'({tx_data, tx_strb}), 0);
    check(rx_valid === 1'b0, "R1", "valid in reset", int'(rx_valid), 0);
    check(link_clk === 1'b0, "R1", "link clock in reset", int'(link_clk), 0);
    exp_words.delete();
    exp_bits.delete();
    @(posedge clk); #1;
    rst = 1'b0;
  endtask

  task automatic measure_period(int exp_cycles);
    realtime t0;
    @(posedge link_clk);
    t0 = $realtime;
    @(posedge link_clk);
    check(int'(($realtime - t0) / 8.0) == exp_cycles, "R2", "link clock period",
          int'(($realtime - t0) / 8.0), exp_cycles);
  endtask

  // Driver: scoreboard items are pushed as each word is presented.
  task automatic send(int n, int kind);
    logic [1:0] v;
    for (int i = 0; i < n; i++) begin
      @(negedge link_clk); #1;
      case (kind)
        0:       v = 2'b00;
        1:       v = 2'b11;
        2:       v = i[0] ? 2'b01 : 2'b10;
        3:       v = i[1:0];
        default: begin
          lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
          v = lfsr[1:0];
        end
      endcase
      tx_word = v;
      tx_en = 1'b1;
      exp_words.push_back(v);
      exp_bits.push_back(v[1]);
      exp_bits.push_back(v[0]);
    end
    @(negedge link_clk); #1;
    tx_en = 1'b0;
  endtask

  task automatic drain(string tag);
    repeat (60) @(posedge clk);
    #1;
    check(exp_bits.size() == 0, "R4", {tag, " bits not sent"}, exp_bits.size(), 0);
    check(exp_words.size() == 0, "R9", {tag, " words not delivered"}, exp_words.size(), 0);
  endtask

  task automatic idle_window(int cycles);
    int c0;
    c0 = line_changes;
    tx_word = 2'b10;
    repeat (cycles) @(posedge clk);
    #1;
    check(line_changes == c0, "R3", "line changes while tx_en low", line_changes - c0, 0);
  endtask

  initial begin
    #(8 * 150000);
    check(0, "R9", "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    do_reset(1'b1);
    measure_period(2);                // R2 full rate
    send(16, 0); drain("R6 zeros");
    send(16, 1); drain("R6 ones");
    send(16, 2); drain("R4 alternating");
    send(16, 3); drain("R7 counter");
    send(40, 4); drain("R9 lfsr");
    idle_window(24);                  // R3 idle
    send(3, 4);  drain("R3 short burst");

    // Reset in the middle of a burst, then half rate.
    fork
      send(8, 3);
    join_none
    repeat (7) @(posedge clk);
    disable fork;
    do_reset(1'b0);
    measure_period(4);                // R2 half rate
    send(16, 2); drain("R4 half alternating");
    send(24, 4); drain("R7 half lfsr");
    idle_window(32);

    do_reset(1'b1);
    send(20, 3); drain("R1 after reset");
    summary();
  end

endmodule